// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps track of frames that a receive MAC has written into a shared receive buffer. Each finished frame leaves one entry in a small queue: its stored byte count and a 4-bit error type. The oldest entry is shown to the host as a 16-bit status word. The host consumes the head frame's payload one byte at a time, or drops the whole head frame with a discard command. The payload RAM itself is outside the block and is modelled only as a count of occupied bytes.

The block also drives four diagnostic flags. The first shows that a frame is arriving. The second shows that the buffer is full. The third shows that the queue holds its maximum number of frames. The fourth is a sticky underrun fault, raised when the host reads past the data held for the head frame. The fault comes with a one-cycle adapter-failure pulse. Only an RX reset or the global reset clears it.

Top module: `rx_frame_queue`

## Requirements
- R1: When at least one finished frame is queued, `status_word` for the oldest one is laid out as follows. Bit 15 is 0. Bits 14..11 hold the frame's error type. Bits 10..0 hold its byte count, clipped to MAX_LEN (1514). A type with bit 14 clear, such as 0010 for dribble bits, denotes a good frame.
- R2: When no finished frame is queued, bit 15 of `status_word` is 1 and bits 14..11 are 0. Bits 10..0 hold the byte count of the frame now arriving, or 0 when no frame is arriving. After reset the word is 16'h8000.
- R3: A frame takes its error type when it ends, in this order of priority. Type 1000 (overrun) applies if any of its bytes was dropped because the buffer was full. Otherwise type 1001 (oversize) applies if more than 1514 bytes were stored. Otherwise the type is the `mac_err` value presented with `mac_end`. The other codes the MAC can report are 1011 runt, 1100 alignment and 1101 CRC.
- R4: The queue holds at most DEPTH (8) finished frames. While it holds DEPTH frames, `stat_ovr` is high and a `mac_start` is refused. The refused frame's bytes and end are then ignored. The flag drops as soon as one frame is discarded.
- R5: `buf_full` rises on the cycle in which BUF_BYTES bytes are held. While it is high, new frames are refused, and bytes of the frame in progress are dropped without being counted. It falls once FREE_THRESH bytes have been freed by reads or discards.
- R6: Each `host_rd` consumes one byte of the head frame. It does not pop the frame. A read with no unread byte left in the head frame, or with no finished frame queued, sets `underrun`. `adapter_fail` then pulses for exactly one cycle. Reads are ignored while `underrun` is high.
- R7: `underrun` stays high until `rx_reset` or `rst_n`. Either one also empties the queue and the buffer and abandons any frame in progress.
- R8: `rx_busy` is high from the cycle after an accepted `mac_start` until the cycle after its `mac_end`.
- R9: `host_discard` removes the oldest finished frame and frees its unread bytes. It takes priority over a read in the same cycle. It has no effect when no finished frame is queued.
- R10: `rx_done` is high for the single cycle after an accepted frame ends. A refused frame never raises it.
- R11: While no frame is arriving, `mac_byte` and `mac_end` are ignored. While a frame is arriving, `mac_start` is ignored, and a `mac_byte` in the same cycle as `mac_end` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| rx_reset | input | 1 | Synchronous RX reset command |
| mac_start | input | 1 | MAC begins a frame |
| mac_byte | input | 1 | MAC stores one payload byte |
| mac_end | input | 1 | MAC ends the frame |
| mac_err | input | 4 | Error type reported with `mac_end` |
| host_rd | input | 1 | Host reads one byte of the head frame |
| host_discard | input | 1 | Host drops the head frame |
| status_word | output | 16 | Head frame status word |
| rx_busy | output | 1 | Frame is being received |
| buf_full | output | 1 | Receive buffer full, reception blocked |
| stat_ovr | output | 1 | Queue holds DEPTH frames |
| underrun | output | 1 | Sticky read-past-data fault |
| adapter_fail | output | 1 | One-cycle pulse when the fault is raised |
| rx_done | output | 1 | One-cycle pulse after a frame completes |

## Verification
Several properties are checked on every cycle:
- the entry count never exceeds DEPTH, and a start at that limit leaves the block idle;
- the byte occupancy never grows while the full flag is high;
- the fault stays sticky until an RX reset, and its failure pulse appears only on the cycle the fault is raised;
- the completion pulse is isolated.

The status-word encoding, the error-type priority, the clipping at 1514 bytes, head ordering through discards, the threshold release of the full flag and the event priorities within a cycle can only be shown by the directed scenarios.

// File: rtl/rx_frame_queue.sv
`timescale 1ns/1ps
module rx_frame_queue #(
  parameter int DEPTH       = 8,
  parameter int BUF_BYTES   = 2048,
  parameter int MAX_LEN     = 1514,
  parameter int FREE_THRESH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        mac_start,
  input  logic        mac_byte,
  input  logic        mac_end,
  input  logic [3:0]  mac_err,
  input  logic        host_rd,
  input  logic        host_discard,
  output logic [15:0] status_word,
  output logic        rx_busy,
  output logic        buf_full,
  output logic        stat_ovr,
  output logic        underrun,
  output logic        adapter_fail,
  output logic        rx_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam logic [LW-1:0] MAXL = LW'(MAX_LEN);
  localparam logic [LW-1:0] BUFL = LW'(BUF_BYTES);
  localparam logic [LW:0]   THR  = (LW+1)'(FREE_THRESH);

  logic [LW-1:0] len_q  [DEPTH];
  logic [3:0]    code_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [LW-1:0] cur_len, head_rd, used, freed_acc;
  logic          busy_q, lost_q, full_q, unr_q, fail_q, done_q;

  function automatic logic [LW-1:0] clip(input logic [LW-1:0] v);
    return (v > MAXL) ? MAXL : v;
  endfunction

  wire has_head  = (cnt != '0);
  wire at_limit  = (cnt == CW'(DEPTH));
  wire start_ok  = mac_start && !busy_q && !at_limit && !full_q;
  wire end_ok    = mac_end && busy_q;
  wire byte_ev   = mac_byte && !mac_end && busy_q;
  wire byte_ok   = byte_ev && !full_q;
  wire byte_lost = byte_ev && full_q;
  wire pop       = host_discard && has_head;
  wire rd_ev     = host_rd && !host_discard && !unr_q;
  wire rd_ok     = rd_ev && has_head && (head_rd < len_q[rd_ptr]);
  wire rd_bad    = rd_ev && !rd_ok;

  wire [LW-1:0] freed   = pop ? (len_q[rd_ptr] - head_rd) : LW'(rd_ok);
  wire [LW-1:0] used_nx = used + LW'(byte_ok) - freed;
  wire [LW:0]   acc_nx  = {1'b0, freed_acc} + {1'b0, freed};
  wire [3:0]    end_code = lost_q ? 4'b1000 : (cur_len > MAXL) ? 4'b1001 : mac_err;

  assign status_word = has_head ? {1'b0, code_q[rd_ptr], 11'(clip(len_q[rd_ptr]))}
                                : {1'b1, 4'b0000, 11'(clip(cur_len))};
  assign rx_busy      = busy_q;
  assign buf_full     = full_q;
  assign stat_ovr     = at_limit;
  assign underrun     = unr_q;
  assign adapter_fail = fail_q;
  assign rx_done      = done_q;

  always_ff @(posedge clk) begin
    if (end_ok && !rx_reset) begin
      len_q[wr_ptr]  <= cur_len;
      code_q[wr_ptr] <= end_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      cur_len <= '0; head_rd <= '0; used <= '0; freed_acc <= '0;
      busy_q <= 1'b0; lost_q <= 1'b0; full_q <= 1'b0;
      unr_q <= 1'b0; fail_q <= 1'b0; done_q <= 1'b0;
    end else if (rx_reset) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      cur_len <= '0; head_rd <= '0; used <= '0; freed_acc <= '0;
      busy_q <= 1'b0; lost_q <= 1'b0; full_q <= 1'b0;
      unr_q <= 1'b0; fail_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= end_ok;
      fail_q <= rd_bad;
      if (rd_bad) unr_q <= 1'b1;

      if (start_ok) begin
        busy_q <= 1'b1; cur_len <= '0; lost_q <= 1'b0;
      end else if (end_ok) begin
        busy_q <= 1'b0; cur_len <= '0; lost_q <= 1'b0;
        wr_ptr <= wr_ptr + 1'b1;
      end else if (byte_ok) begin
        cur_len <= cur_len + 1'b1;
      end else if (byte_lost) begin
        lost_q <= 1'b1;
      end

      cnt <= cnt + CW'(end_ok) - CW'(pop);
      if (pop) begin
        rd_ptr  <= rd_ptr + 1'b1;
        head_rd <= '0;
      end else if (rd_ok) begin
        head_rd <= head_rd + 1'b1;
      end

      used <= used_nx;
      if (!full_q) begin
        if (used_nx == BUFL) begin
          full_q    <= 1'b1;
          freed_acc <= '0;
        end
      end else if (acc_nx >= THR) begin
        full_q    <= 1'b0;
        freed_acc <= '0;
      end else begin
        freed_acc <= acc_nx[LW-1:0];
      end
    end
  end

  assert_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovr && mac_start && !rx_busy) |=> !rx_busy);
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> (used <= $past(used)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !rx_reset) |=> underrun);
  assert_fail_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_fail |-> (underrun && !$past(underrun)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !rx_busy);
endmodule

// File: tb/sim_rx_frame_queue.sv
`timescale 1ns/1ps
module sim_rx_frame_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_reset = 1'b0, mac_start = 1'b0, mac_byte = 1'b0, mac_end = 1'b0;
  logic [3:0] mac_err = 4'h0;
  logic host_rd = 1'b0, host_discard = 1'b0;
  logic [15:0] status_word;
  logic rx_busy, buf_full, stat_ovr, underrun, adapter_fail, rx_done;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rx_frame_queue u0 (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end), .mac_err(mac_err),
    .host_rd(host_rd), .host_discard(host_discard),
    .status_word(status_word), .rx_busy(rx_busy), .buf_full(buf_full),
    .stat_ovr(stat_ovr), .underrun(underrun), .adapter_fail(adapter_fail), .rx_done(rx_done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic b, input logic e, input logic [3:0] err,
                      input logic rd, input logic dc, input logic rr);
    @(negedge clk);
    mac_start = s; mac_byte = b; mac_end = e; mac_err = err;
    host_rd = rd; host_discard = dc; rx_reset = rr;
  endtask

  task automatic idle();
    step(0, 0, 0, 4'h0, 0, 0, 0);
  endtask

  task automatic send_frame(input int n, input logic [3:0] err);
    step(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < n; i++) step(0, 1, 0, 4'h0, 0, 0, 0);
    step(0, 0, 1, err, 0, 0, 0);
    idle();
  endtask

  task automatic discard();
    step(0, 0, 0, 4'h0, 0, 1, 0);
    idle();
  endtask

  task automatic rx_rst();
    step(0, 0, 0, 4'h0, 0, 0, 1);
    idle();
  endtask

  task automatic t_reset();
    chk("R2 reset status", status_word, 16'h8000);
    chk("R7 reset flags", {10'd0, rx_busy, buf_full, stat_ovr, underrun, adapter_fail, rx_done}, 16'h0000);
  endtask

  task automatic t_progress();
    step(1, 0, 0, 4'h0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 4'h0, 0, 0, 0);
    idle();
    chk("R8 busy during frame", {15'd0, rx_busy}, 16'h0001);
    chk("R2 in-progress status", status_word, 16'h8005);
    step(0, 0, 1, 4'h0, 0, 0, 0);
    idle();
    chk("R10 done pulse", {15'd0, rx_done}, 16'h0001);
    chk("R8 busy after end", {15'd0, rx_busy}, 16'h0000);
    chk("R1 finished status", status_word, 16'h0005);
    idle();
    chk("R10 done one cycle", {15'd0, rx_done}, 16'h0000);
    discard();
    chk("R9 discard empties", status_word, 16'h8000);
  endtask

  task automatic t_codes();
    send_frame(60, 4'h0);
    chk("R1 good frame", status_word, 16'h003C);
    discard();
    send_frame(70, 4'hD);
    chk("R3 crc code", status_word, 16'h6846);
    discard();
    send_frame(1520, 4'h0);
    chk("R3 oversize clipped", status_word, 16'h4DEA);
    discard();
    send_frame(10, 4'h2);
    chk("R1 dribble code", status_word, 16'h100A);
    discard();
  endtask

  task automatic t_limit();
    for (int i = 1; i <= 8; i++) send_frame(i, 4'h0);
    chk("R4 limit flag", {15'd0, stat_ovr}, 16'h0001);
    step(1, 0, 0, 4'h0, 0, 0, 0);
    idle();
    chk("R4 start refused", {15'd0, rx_busy}, 16'h0000);
    step(0, 1, 0, 4'h0, 0, 0, 0);
    step(0, 0, 1, 4'h0, 0, 0, 0);
    idle();
    chk("R10 no done for refused", {15'd0, rx_done}, 16'h0000);
    chk("R4 head unchanged", status_word, 16'h0001);
    discard();
    chk("R4 limit cleared", {15'd0, stat_ovr}, 16'h0000);
    chk("R9 next head", status_word, 16'h0002);
    send_frame(20, 4'h0);
    chk("R4 accepted after discard", {15'd0, rx_done}, 16'h0001);
    discard();
    for (int k = 3; k <= 8; k++) begin
      chk("R9 order", status_word, 16'(k));
      discard();
    end
    chk("R9 last frame", status_word, 16'h0014);
    discard();
    discard();
    chk("R9 empty discard", status_word, 16'h8000);
    chk("R9 empty discard no fault", {15'd0, underrun}, 16'h0000);
  endtask

  task automatic t_read();
    rx_rst();
    send_frame(3, 4'h0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R6 reads in range", {15'd0, underrun}, 16'h0000);
    chk("R6 read does not pop", status_word, 16'h0003);
    step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R6 underrun set", {15'd0, underrun}, 16'h0001);
    chk("R6 fail pulse", {15'd0, adapter_fail}, 16'h0001);
    idle();
    chk("R6 fail pulse ends", {15'd0, adapter_fail}, 16'h0000);
    step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R6 no second pulse", {15'd0, adapter_fail}, 16'h0000);
    send_frame(4, 4'h0);
    discard();
    chk("R7 sticky", {15'd0, underrun}, 16'h0001);
    rx_rst();
    chk("R7 rx reset clears", {15'd0, underrun}, 16'h0000);
    chk("R7 rx reset empties", status_word, 16'h8000);
    step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R6 read on empty", {15'd0, underrun}, 16'h0001);
    rx_rst();
  endtask

  task automatic t_full();
    send_frame(2050, 4'h0);
    chk("R5 full flag", {15'd0, buf_full}, 16'h0001);
    chk("R3 overrun code", status_word, 16'h45EA);
    step(1, 0, 0, 4'h0, 0, 0, 0);
    idle();
    chk("R5 start refused", {15'd0, rx_busy}, 16'h0000);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R5 below threshold", {15'd0, buf_full}, 16'h0001);
    step(0, 0, 0, 4'h0, 1, 0, 0);
    idle();
    chk("R5 threshold release", {15'd0, buf_full}, 16'h0000);
    send_frame(1, 4'h0);
    chk("R5 accepted after release", {15'd0, rx_done}, 16'h0001);
    rx_rst();
  endtask

  task automatic t_prio();
    step(0, 1, 0, 4'h0, 0, 0, 0);
    step(0, 0, 1, 4'h0, 0, 0, 0);
    idle();
    chk("R11 idle end ignored", {15'd0, rx_done}, 16'h0000);
    chk("R11 idle byte ignored", status_word, 16'h8000);
    step(1, 1, 0, 4'h0, 0, 0, 0);
    step(0, 1, 0, 4'h0, 0, 0, 0);
    step(1, 1, 0, 4'h0, 0, 0, 0);
    step(0, 1, 1, 4'h0, 0, 0, 0);
    idle();
    chk("R11 priority count", status_word, 16'h0002);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_progress();
    t_codes();
    t_limit();
    t_read();
    t_full();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule